// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block converts single-word requests from an on-chip client into the command stream of a single-data-rate SDRAM with four banks. Each bank holds 4096 rows of 256 sixteen-bit words. The block runs the power-up sequence and programs the mode register. It then serves requests one at a time. For each request it issues precharge, activate and column commands with the spacing that the timing parameters set. All timing parameters are counted in clock cycles.

The block remembers the open row of every bank. A request to a row that is already open goes straight to the column command. A request to a bank whose row is closed needs an activate first. A request to a bank that holds a different row needs a precharge, then an activate. Because the row state is kept per bank, work in one bank can proceed while another bank has a row open or is still finishing its precharge.

A request may ask for auto-precharge. The device then closes the row after the access, and the block marks that bank closed for the time the device needs. A free-running interval timer asks for periodic refresh. The refresh request is served at the next idle point: the block closes all banks, then issues the refresh.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: The request address splits into column = bits [7:0], bank = bits [9:8] and row = bits [21:10]. The row goes out on `sd_addr` with ACTIVE. The column goes out on `sd_addr[7:0]` with READ or WRITE. The bank goes out on `sd_ba` with ACTIVE, READ, WRITE and single-bank PRECHARGE.
- R2: The command on {cs_n, ras_n, cas_n, we_n} is one of the following: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000. The command is NOP in reset.
- R3: After reset, `req_ready` stays low while the block waits at least INIT_CYCLES cycles. The block then issues PRECHARGE with `sd_addr[10]`=1 (all banks), then two REFRESH commands, then LOAD MODE. The LOAD MODE word carries the burst code in `sd_addr[2:0]` and the CAS latency in `sd_addr[6:4]`; all other bits are 0. There are at least T_RP cycles after the PRECHARGE, at least T_RFC cycles after each REFRESH, and at least T_MRD cycles after LOAD MODE before the first request is accepted.
- R4: If a request targets a bank that has its row open, READ or WRITE appears on the bus in the cycle after the handshake. `sd_addr[10]` on that command equals `req_autopre`. READ and WRITE are issued only to a bank whose row is open.
- R5: If a request targets a closed bank that is not cooling down, ACTIVE appears in the cycle after the handshake, and the access appears T_RCD cycles after the ACTIVE. ACTIVE is issued only to a closed bank.
- R6: If a request targets a bank that holds another row, PRECHARGE to that bank with `sd_addr[10]`=0 appears in the cycle after the handshake. ACTIVE follows T_RP cycles later, and the access follows T_RCD cycles after the ACTIVE.
- R7: After an access with auto-precharge, the bank counts as closed. The next request to that bank starts with ACTIVE and no PRECHARGE, and that ACTIVE comes no sooner than T_RP plus the burst length after the access.
- R8: For every READ, `rsp_valid` is high for exactly one cycle, CAS_LAT+1 cycles after the READ is on the bus. At that point `rsp_data` holds the word the device drove on `sd_dq_in` CAS_LAT cycles after the READ.
- R9: `sd_dq_oe` is high exactly in the cycles that carry WRITE, and `sd_dq_out` then holds that request's write data.
- R10: Every REFRESH_INTERVAL cycles a refresh becomes due. It is served before any further request: PRECHARGE to all banks if any row is open, then REFRESH with all banks closed, at least T_RP cycles after the last precharge. No command other than NOP follows for T_RFC cycles.
- R11: `req_ready` is low from the handshake until the command sequence of that request has been issued. It is also low while a refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a cycle where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| req_addr | input | 22 | Word address {row, bank, column} |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row, column or mode word |
| sd_dq_out | output | 16 | Data toward the device |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data from the device |

## Verification
After each handshake the bench first decides from its own bus-derived row table whether the request is a hit, a closed bank or a row miss. It then samples the bus exactly 1, 1+T_RP and 1+T_RP+T_RCD cycles later, whichever of those apply. Each READ seen on the bus queues a due cycle CAS_LAT+1 ahead, and the response monitor compares both the data and the cycle in which `rsp_valid` appears. A bus monitor enforces the minimum spacings after precharge, activate and refresh on every command.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int ROW_W     = 12;
    localparam int BANK_W    = 2;
    localparam int COL_W     = 8;
    localparam int NUM_BANKS = 4;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = ROW_W + BANK_W + COL_W;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } sdr_addr_t;

    typedef struct packed {
        logic              write;
        logic              autopre;
        sdr_addr_t         addr;
        logic [DATA_W-1:0] wdata;
    } sdr_req_t;

    typedef struct packed {
        sdr_cmd_e          cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
    } sdr_bus_t;

    function automatic int burst_words(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd7:    return 256;
            default: return 1;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] mode_word(input int cl, input logic [2:0] code);
        logic [ROW_W-1:0] mw;
        mw      = '0;
        mw[2:0] = code;
        mw[6:4] = 3'(cl);
        return mw;
    endfunction

endpackage

// File: rtl/sdr_bank_table.sv
module sdr_bank_table
    import sdr_pkg::*;
#(
    parameter int NB   = NUM_BANKS,
    parameter int RW   = ROW_W,
    parameter int CD_W = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   open_en,
    input  logic [$clog2(NB)-1:0]  open_bank,
    input  logic [RW-1:0]          open_row,
    input  logic                   close_en,
    input  logic [$clog2(NB)-1:0]  close_bank,
    input  logic                   close_all,
    input  logic [CD_W-1:0]        close_cd,
    output logic [NB-1:0]          open_vec,
    output logic [NB-1:0][RW-1:0]  rows,
    output logic [NB-1:0]          cd_zero
);
    localparam int BW = $clog2(NB);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [CD_W-1:0] cd;
        logic            shut;

        assign shut       = close_all || (close_en && close_bank == BW'(b));
        assign cd_zero[b] = (cd == '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                open_vec[b] <= 1'b0;
                rows[b]     <= '0;
                cd          <= '0;
            end else if (shut) begin
                open_vec[b] <= 1'b0;
                cd          <= close_cd;
            end else begin
                if (cd != '0) cd <= cd - 1'b1;
                if (open_en && open_bank == BW'(b)) begin
                    open_vec[b] <= 1'b1;
                    rows[b]     <= open_row;
                end
            end
        end
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (run) cnt <= tick ? '0 : cnt + 1'b1;
            pend <= tick || (pend && !ack);
        end
    end

endmodule

// File: rtl/sdr_read_return.sv
module sdr_read_return #(
    parameter int CL = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_issue,
    input  logic [DW-1:0] dq_in,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    // trk[k] is high in the k-th cycle after a READ reached the bus
    logic [CL:0] trk;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            trk       <= {trk[CL-1:0], rd_issue};
            rsp_valid <= trk[CL];
            if (trk[CL]) rsp_data <= dq_in;
        end
    end

endmodule

// File: rtl/sdr_cmd_ctrl.sv
module sdr_cmd_ctrl
    import sdr_pkg::*;
#(
    parameter int         INIT_CYCLES      = 10000,
    parameter int         T_RCD            = 2,
    parameter int         T_RP             = 2,
    parameter int         T_RFC            = 7,
    parameter int         T_MRD            = 2,
    parameter int         CAS_LAT          = 2,
    parameter int         REFRESH_INTERVAL = 780,
    parameter logic [2:0] BURST_CODE       = 3'd0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_autopre,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]    sd_addr,
    output logic [DATA_W-1:0]   sd_dq_out,
    output logic                sd_dq_oe,
    input  logic [DATA_W-1:0]   sd_dq_in
);
    localparam int BL_WORDS = burst_words(BURST_CODE);
    localparam int AP_CD    = T_RP + BL_WORDS - 1;
    localparam int CD_W     = $clog2(AP_CD + 2);
    localparam int WAIT_MAX = INIT_CYCLES + T_RFC + T_RP + T_MRD + T_RCD;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam logic [ROW_W-1:0] MODE = mode_word(CAS_LAT, BURST_CODE);

    typedef enum logic [3:0] {
        ST_INIT_WAIT, ST_INIT_PALL, ST_INIT_REF1, ST_INIT_REF2, ST_INIT_MRS,
        ST_IDLE, ST_OPEN, ST_ACCESS, ST_REF_WAIT
    } state_e;

    state_e             state, nxt_state;
    logic [WAIT_W-1:0]  wait_cnt, nxt_wait;
    logic               wait0;
    sdr_req_t           cur, in_req, sel;
    sdr_bus_t           bus_q, bus_nxt;
    logic               init_done;
    logic               take, do_act, do_access, rd_issue, wr_issue;
    logic               open_en, close_en, close_all;
    logic [CD_W-1:0]    close_cd;
    logic [NUM_BANKS-1:0]            open_vec, cd_zero;
    logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
    logic               ref_pend, ref_ack;
    logic               tgt_open, tgt_hit;

    assign in_req.write   = req_write;
    assign in_req.autopre = req_autopre;
    assign in_req.addr    = sdr_addr_t'(req_addr);
    assign in_req.wdata   = req_wdata;

    assign wait0     = (wait_cnt == '0);
    assign req_ready = (state == ST_IDLE) && wait0 && !ref_pend;
    assign sel       = (state == ST_IDLE) ? in_req : cur;
    assign tgt_open  = open_vec[sel.addr.bank];
    assign tgt_hit   = tgt_open && (rows[sel.addr.bank] == sel.addr.row);

    always_comb begin
        nxt_state = state;
        nxt_wait  = wait0 ? '0 : wait_cnt - 1'b1;
        bus_nxt   = '{cmd: CMD_NOP, ba: '0, a: '0};
        take      = 1'b0;
        do_act    = 1'b0;
        do_access = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        close_cd  = CD_W'(T_RP - 1);
        ref_ack   = 1'b0;
        case (state)
            ST_INIT_WAIT: if (wait0) nxt_state = ST_INIT_PALL;
            ST_INIT_PALL: begin
                bus_nxt.cmd   = CMD_PRE;
                bus_nxt.a[10] = 1'b1;
                close_all     = 1'b1;
                nxt_wait      = WAIT_W'(T_RP - 1);
                nxt_state     = ST_INIT_REF1;
            end
            ST_INIT_REF1, ST_INIT_REF2: if (wait0) begin
                bus_nxt.cmd = CMD_REF;
                nxt_wait    = WAIT_W'(T_RFC - 1);
                nxt_state   = (state == ST_INIT_REF1) ? ST_INIT_REF2 : ST_INIT_MRS;
            end
            ST_INIT_MRS: if (wait0) begin
                bus_nxt.cmd = CMD_MRS;
                bus_nxt.a   = MODE;
                nxt_wait    = WAIT_W'(T_MRD - 1);
                nxt_state   = ST_IDLE;
            end
            ST_IDLE: if (wait0) begin
                if (ref_pend) begin
                    if (|open_vec) begin
                        bus_nxt.cmd   = CMD_PRE;
                        bus_nxt.a[10] = 1'b1;
                        close_all     = 1'b1;
                    end
                    nxt_state = ST_REF_WAIT;
                end else if (req_valid) begin
                    take = 1'b1;
                    if (tgt_hit) begin
                        do_access = 1'b1;
                    end else if (tgt_open) begin
                        bus_nxt.cmd = CMD_PRE;
                        bus_nxt.ba  = sel.addr.bank;
                        close_en    = 1'b1;
                        nxt_state   = ST_OPEN;
                    end else if (cd_zero[sel.addr.bank]) begin
                        do_act = 1'b1;
                    end else begin
                        nxt_state = ST_OPEN;
                    end
                end
            end
            ST_OPEN: if (cd_zero[sel.addr.bank]) do_act = 1'b1;
            ST_ACCESS: if (wait0) begin
                do_access = 1'b1;
                nxt_state = ST_IDLE;
            end
            ST_REF_WAIT: if (&cd_zero) begin
                bus_nxt.cmd = CMD_REF;
                ref_ack     = 1'b1;
                nxt_wait    = WAIT_W'(T_RFC - 1);
                nxt_state   = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase

        if (do_act) begin
            bus_nxt.cmd = CMD_ACT;
            bus_nxt.ba  = sel.addr.bank;
            bus_nxt.a   = sel.addr.row;
            nxt_wait    = WAIT_W'(T_RCD - 1);
            nxt_state   = ST_ACCESS;
        end
        if (do_access) begin
            bus_nxt.cmd      = sel.write ? CMD_WR : CMD_RD;
            bus_nxt.ba       = sel.addr.bank;
            bus_nxt.a        = ROW_W'(sel.addr.col);
            bus_nxt.a[10]    = sel.autopre;
            nxt_state        = ST_IDLE;
            if (sel.autopre) begin
                close_en = 1'b1;
                close_cd = CD_W'(AP_CD);
            end
        end
    end

    assign open_en  = do_act;
    assign rd_issue = do_access && !sel.write;
    assign wr_issue = do_access && sel.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT_WAIT;
            wait_cnt  <= WAIT_W'(INIT_CYCLES - 1);
            bus_q     <= '{cmd: CMD_NOP, ba: '0, a: '0};
            cur       <= '0;
            init_done <= 1'b0;
            sd_dq_oe  <= 1'b0;
            sd_dq_out <= '0;
        end else begin
            state    <= nxt_state;
            wait_cnt <= nxt_wait;
            bus_q    <= bus_nxt;
            sd_dq_oe <= wr_issue;
            if (take) cur <= in_req;
            if (wr_issue) sd_dq_out <= sel.wdata;
            if (bus_nxt.cmd == CMD_MRS) init_done <= 1'b1;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_q.cmd;
    assign sd_ba   = bus_q.ba;
    assign sd_addr = bus_q.a;

    sdr_bank_table #(.NB(NUM_BANKS), .RW(ROW_W), .CD_W(CD_W)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .open_en    (open_en),
        .open_bank  (sel.addr.bank),
        .open_row   (sel.addr.row),
        .close_en   (close_en),
        .close_bank (sel.addr.bank),
        .close_all  (close_all),
        .close_cd   (close_cd),
        .open_vec   (open_vec),
        .rows       (rows),
        .cd_zero    (cd_zero)
    );

    sdr_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .run  (init_done),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    sdr_read_return #(.CL(CAS_LAT), .DW(DATA_W)) u_rdret (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (rd_issue),
        .dq_in     (sd_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/sdr_ctrl_checker.sv
module sdr_ctrl_checker #(
    parameter int CAS_LAT = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       init_done,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [3:0] cmd,
    input logic [1:0] ba,
    input logic [3:0] open_vec
);
    logic [3:0] ba_sel;
    assign ba_sel = 4'b0001 << ba;

    AST_NO_READY_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !req_ready); // R3

    AST_RW_TO_OPEN_BANK: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0101 || cmd == 4'b0100) |-> (($past(open_vec) & ba_sel) != 4'b0000)); // R4

    AST_ACT_TO_CLOSED_BANK: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0011) |-> (($past(open_vec) & ba_sel) == 4'b0000)); // R5

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd == 4'b0101, CAS_LAT + 1)); // R8

    AST_REFRESH_ALL_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001) |-> (open_vec == 4'b0000)); // R10

endmodule

bind sdr_cmd_ctrl sdr_ctrl_checker #(.CAS_LAT(CAS_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_done (init_done),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .ba        (sd_ba),
    .open_vec  (open_vec)
);

// File: tb/sdr_cmd_ctrl_bench.sv
module sdr_cmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_CYC   = 40;
    localparam int TRCD       = 2;
    localparam int TRP        = 3;
    localparam int TRFC       = 6;
    localparam int TMRD       = 2;
    localparam int CL         = 3;
    localparam int REF_INT    = 400;
    localparam int BLW        = 1;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0, req_autopre = 0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_data, sd_dq_out, sd_dq_in;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [3:0]  cmd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_cmd_ctrl #(
        .INIT_CYCLES(INIT_CYC), .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC),
        .T_MRD(TMRD), .CAS_LAT(CL), .REFRESH_INTERVAL(REF_INT), .BURST_CODE(3'd0)
    ) u_sdr_cmd_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    int vectors = 0, fails = 0, cyc = 0, rel_cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- device model and bus monitor ----------------
    bit          sh_open [4];
    logic [11:0] sh_row  [4];
    int          last_act [4], last_close [4];
    bit          ap_pend [4];
    int          last_ref = -1000, ref_count = 0, init_idx = 0;
    bit          early_ready = 0;
    logic [15:0] mem [int];
    logic [15:0] pipe [CL];
    int          due_q [$];
    logic [15:0] exp_q [$];

    assign sd_dq_in = pipe[0];

    initial begin
        for (int b = 0; b < 4; b++) begin
            sh_open[b] = 0; sh_row[b] = '0; last_act[b] = -1000;
            last_close[b] = -1000; ap_pend[b] = 0;
        end
        for (int k = 0; k < CL; k++) pipe[k] = '0;
    end

    always @(posedge clk) begin
        int key;
        key = int'({sh_row[sd_ba], sd_ba, sd_addr[7:0]});
        for (int k = 0; k < CL-1; k++) pipe[k] <= pipe[k+1];
        pipe[CL-1] <= (!rst && cmd == C_RD && mem.exists(key)) ? mem[key] : 16'h0000;
    end

    always @(negedge clk) begin
        int key, lc;
        if (!rst) begin
            if (init_idx < 4 && req_ready) early_ready = 1;
            if (cmd != C_NOP) begin
                chk(cyc - last_ref >= TRFC, "R10", "gap after refresh", cyc - last_ref, TRFC);
                if (init_idx < 4) begin
                    case (init_idx)
                        0: begin
                            chk(cmd == C_PRE && sd_addr[10], "R3", "init precharge-all", cmd, C_PRE);
                            chk(cyc - rel_cyc >= INIT_CYC, "R3", "init wait", cyc - rel_cyc, INIT_CYC);
                        end
                        1, 2: chk(cmd == C_REF, "R3", "init refresh", cmd, C_REF);
                        default: begin
                            chk(cmd == C_MRS, "R3", "load mode", cmd, C_MRS);
                            chk(sd_addr == 12'h030, "R3", "mode word", sd_addr, 12'h030);
                            chk(!early_ready, "R3", "ready during init", early_ready, 0);
                        end
                    endcase
                    init_idx++;
                end
            end
            lc = -1000;
            for (int b = 0; b < 4; b++) if (last_close[b] > lc) lc = last_close[b];
            case (cmd)
                C_ACT: begin
                    chk(!sh_open[sd_ba], "R5", "activate on open bank", sh_open[sd_ba], 0);
                    chk(cyc - last_close[sd_ba] >= TRP, "R7", "activate too early",
                        cyc - last_close[sd_ba], TRP);
                    sh_open[sd_ba] = 1; sh_row[sd_ba] = sd_addr;
                    last_act[sd_ba] = cyc; ap_pend[sd_ba] = 0;
                end
                C_PRE: begin
                    for (int b = 0; b < 4; b++)
                        if (sd_addr[10] || sd_ba == 2'(b)) begin
                            sh_open[b] = 0; last_close[b] = cyc;
                        end
                end
                C_RD, C_WR: begin
                    chk(sh_open[sd_ba], "R4", "access to closed bank", sh_open[sd_ba], 1);
                    chk(cyc - last_act[sd_ba] >= TRCD, "R5", "activate to access",
                        cyc - last_act[sd_ba], TRCD);
                    key = int'({sh_row[sd_ba], sd_ba, sd_addr[7:0]});
                    if (cmd == C_WR) begin
                        chk(sd_dq_oe, "R9", "oe with write", sd_dq_oe, 1);
                        mem[key] = sd_dq_out;
                    end else begin
                        due_q.push_back(cyc + CL + 1);
                    end
                    if (sd_addr[10]) begin
                        sh_open[sd_ba] = 0; last_close[sd_ba] = cyc + BLW; ap_pend[sd_ba] = 1;
                    end
                end
                C_REF: if (init_idx > 1) begin
                    chk(!(sh_open[0] || sh_open[1] || sh_open[2] || sh_open[3]), "R10",
                        "refresh with open bank", {sh_open[3], sh_open[2], sh_open[1], sh_open[0]}, 0);
                    chk(cyc - lc >= TRP, "R10", "precharge to refresh", cyc - lc, TRP);
                    last_ref = cyc; ref_count++;
                end else last_ref = cyc;
                default: ;
            endcase
            if (cmd != C_WR && sd_dq_oe) chk(0, "R9", "oe without write", 1, 0);
        end
    end

    // ---------------- response monitor (scoreboard) ----------------
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (due_q.size() == 0 || exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected response", rsp_data, 0);
                end else begin
                    chk(due_q[0] == cyc, "R8", "response cycle", cyc, due_q[0]);
                    chk(rsp_data == exp_q[0], "R8", "read data", rsp_data, exp_q[0]);
                    void'(due_q.pop_front());
                    void'(exp_q.pop_front());
                end
            end else if (due_q.size() != 0 && due_q[0] == cyc) begin
                chk(0, "R8", "missing response", 0, 1);
                void'(due_q.pop_front());
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
        end
    end

    // ---------------- driver ----------------
    logic [15:0] model [int];

    function automatic logic [21:0] mk(input int row, input int bank, input int col);
        return {12'(row), 2'(bank), 8'(col)};
    endfunction

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk_access(input bit w, input logic [21:0] a, input bit ap);
        chk(cmd == (w ? C_WR : C_RD), "R4", "access command", cmd, w ? C_WR : C_RD);
        chk(sd_ba == a[9:8] && sd_addr[7:0] == a[7:0], "R1", "access bank/column",
            {sd_ba, sd_addr[7:0]}, a[9:0]);
        chk(sd_addr[10] == ap, "R7", "auto-precharge flag", sd_addr[10], ap);
        if (w) chk(sd_dq_out == req_wdata, "R9", "write data", sd_dq_out, req_wdata);
    endtask

    task automatic do_req(input bit w, input logic [21:0] a, input logic [15:0] d, input bit ap);
        int b, waited;
        bit hit, miss, append;
        b = int'(a[9:8]);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_autopre = ap;
        while (!req_ready) step();
        hit    = sh_open[b] && sh_row[b] == a[21:10];
        miss   = sh_open[b] && !hit;
        append = ap_pend[b];
        if (w) model[int'(a)] = d;
        else exp_q.push_back(model.exists(int'(a)) ? model[int'(a)] : 16'h0000);
        @(posedge clk); step();
        req_valid = 0;
        if (hit) begin
            chk_access(w, a, ap);
        end else if (miss) begin
            chk(cmd == C_PRE && sd_ba == a[9:8] && !sd_addr[10], "R6", "row-miss precharge",
                {cmd, sd_ba}, {C_PRE, a[9:8]});
            chk(!req_ready, "R11", "ready while busy", req_ready, 0);
            repeat (TRP) step();
            chk(cmd == C_ACT && sd_addr == a[21:10], "R6", "activate after tRP", {cmd, sd_addr},
                {C_ACT, a[21:10]});
            repeat (TRCD) step();
            chk_access(w, a, ap);
        end else begin
            waited = 0;
            while (cmd == C_NOP && waited < 60) begin step(); waited++; end
            chk(cmd == C_ACT && sd_ba == a[9:8] && sd_addr == a[21:10], "R5",
                "activate row", {cmd, sd_ba, sd_addr}, {C_ACT, a[9:8], a[21:10]});
            if (!append) chk(waited == 0, "R5", "activate cycle", waited, 0);
            else chk(waited > 0, "R7", "cool-down after auto-precharge", waited, 1);
            repeat (TRCD) step();
            chk_access(w, a, ap);
        end
        req_autopre = 0;
    endtask

    initial begin
        int r0;
        repeat (3) step();
        chk(!req_ready, "R3", "ready in reset", req_ready, 0);
        chk(cmd == C_NOP, "R2", "NOP in reset", cmd, C_NOP);
        rst = 0; rel_cyc = cyc;
        repeat (2) step();
        chk(cmd == C_NOP && !req_ready, "R3", "idle after reset", {cmd, req_ready}, {C_NOP, 1'b0});

        do_req(1, mk(5, 0, 3), 16'hA5A1, 0);
        do_req(1, mk(5, 0, 4), 16'h5A52, 0);
        do_req(0, mk(5, 0, 3), 16'h0, 0);
        do_req(0, mk(5, 0, 4), 16'h0, 0);
        do_req(1, mk(7, 1, 10), 16'h1234, 0);
        do_req(0, mk(5, 0, 3), 16'h0, 0);
        do_req(1, mk(9, 0, 200), 16'hBEEF, 0);
        do_req(0, mk(9, 0, 200), 16'h0, 0);
        do_req(0, mk(5, 0, 4), 16'h0, 0);
        do_req(1, mk(1, 2, 0), 16'hC0DE, 1);
        do_req(0, mk(1, 2, 0), 16'h0, 0);
        do_req(0, mk(7, 1, 10), 16'h0, 1);
        do_req(0, mk(7, 1, 10), 16'h0, 0);
        do_req(1, mk(4095, 3, 255), 16'hFFFE, 0);
        do_req(0, mk(4095, 3, 255), 16'h0, 0);
        for (int i = 0; i < 6; i++) do_req(1, mk(33, 1, 16 + i), 16'(16'h7000 + i), 0);
        for (int i = 5; i >= 0; i--) do_req(0, mk(33, 1, 16 + i), 16'h0, 0);

        r0 = ref_count;
        repeat (3 * REF_INT) step();
        chk(ref_count - r0 >= 2 && ref_count - r0 <= 4, "R10", "refresh count",
            ref_count - r0, 3);
        do_req(0, mk(5, 0, 3), 16'h0, 0);
        do_req(0, mk(4095, 3, 255), 16'h0, 0);

        repeat (20) step();
        chk(exp_q.size() == 0 && due_q.size() == 0, "R8", "responses drained",
            exp_q.size() + due_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule